// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Controller

This block sits between a synchronous host and an asynchronous parallel read-only memory that offers a fast in-page read. The host hands over one request at a time on a valid/ready handshake. Each request holds a start address and a word count. The controller then drives the chip enable, the output enable, the data-width strap and the address pins. It counts wait cycles and samples the data pins on the clock edge that ends the count. Each captured word goes back to the host as a one-cycle response. The final word of the request carries a last flag.

Each wait is a cycle count set by a parameter. The count is the nanosecond figure divided by the clock period and rounded up. The full random wait (`RAND_CYC`) applies to the first word of every request and to any word whose address bits from A3 upward differ from the previous word. The shorter page wait (`PAGE_CYC`) applies when only the in-page bits change. A static mode input selects 32-bit words or 16-bit half-words. In 16-bit mode the top data pin becomes the lowest address bit and is driven by the controller. After a burst, both enables go high. The controller then waits `TURN_CYC` cycles, so the memory has released its outputs before anything is driven onto the shared pin again.

The state machine has four states:
- `ST_IDLE`: ready for a request.
- `ST_RAND`: a random-access wait is running.
- `ST_PAGE`: an in-page wait is running.
- `ST_TURN`: the output-release wait after a burst.

The state transitions are:
- ACCEPT: `ST_IDLE`→`ST_RAND`.
- PAGE_HIT: `ST_RAND`/`ST_PAGE`→`ST_PAGE`, when a word is captured, more words remain and the tag is unchanged.
- PAGE_MISS: `ST_RAND`/`ST_PAGE`→`ST_RAND`, when a word is captured, more words remain and the tag changes.
- FINISH: `ST_RAND`/`ST_PAGE`→`ST_TURN`, when the final word is captured.
- RELEASE: `ST_TURN`→`ST_IDLE`, when the turnaround count expires.

Top module: `prom_page_reader`

## Requirements
- R1: While reset is low, chip enable and output enable are high (inactive), `rsp_valid` is 0, `mem_hsel_en` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only in `ST_IDLE`. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. While a burst or its turnaround runs, `req_ready` is 0 and `req_valid` has no effect.
- R3: The first word of a request is captured on the edge that comes `RAND_CYC` edges after the accepting edge. Chip enable and output enable go low on the accepting edge. `rsp_valid` is high during the following cycle.
- R4: A following word whose address bits from A3 upward equal those of the previous word is captured `PAGE_CYC` edges after the previous capture.
- R5: A following word whose bits from A3 upward differ (a page crossing) is captured `RAND_CYC` edges after the previous capture. The enables stay low between words of a burst.
- R6: In 32-bit mode (`mode_x16`=0), word n of a request goes out on `mem_addr` as (`req_addr` + n) mod 2^27. Bit 27 of `req_addr` is ignored. `rsp_data` equals all 32 data pins, and a page is 8 words.
- R7: In 16-bit mode (`mode_x16`=1), half-word n uses h = (`req_addr` + n) mod 2^28. The pins carry `mem_addr` = h[27:1] and `mem_hsel` = h[0], with `mem_hsel_en` = 1. `rsp_data` = {16'h0, data pins [15:0]}, and a page is 16 half-words.
- R8: A request with `req_len` = L returns exactly L+1 responses. `rsp_last` is 1 on the final response only.
- R9: On the final capture edge, chip enable, output enable and `mem_hsel_en` go inactive. `req_ready` returns `TURN_CYC` edges later.
- R10: `mem_wide` equals the inverse of `mode_x16` as sampled on edges in `ST_IDLE`. A change of `mode_x16` during a burst does not alter `mem_wide` or the running burst.
- R11: Chip enable and output enable are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_x16 | input | 1 | 1 = 16-bit half-word mode, 0 = 32-bit mode |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | AW+1 (28) | Start word or half-word address |
| req_len | input | LW (8) | Number of words minus one |
| rsp_valid | output | 1 | Response word valid for one cycle |
| rsp_data | output | DW (32) | Captured word |
| rsp_last | output | 1 | Final word of the request |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_wide | output | 1 | Width strap, 1 = 32-bit |
| mem_addr | output | AW (27) | Memory address pins A0 upward |
| mem_hsel | output | 1 | Half-word select value for the shared top data pin |
| mem_hsel_en | output | 1 | Drive enable for the shared top data pin |
| mem_dq | input | DW (32) | Memory data pins |

## Verification
The hardest situation to reach from the ports is a burst that mixes in-page steps with a page crossing. This includes a crossing that wraps past the top of the address space, in both widths. The memory model in the bench returns garbage until the address has been stable for the correct window, so a wrong wait choice shows up as bad data. The stimulus starts bursts just below a page edge and just below the top address. It also flips the width input in the middle of a 16-bit burst, and issues back-to-back requests with `req_valid` held high, so the turnaround gap is exercised.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RAND,
        ST_PAGE,
        ST_TURN
    } rd_state_t;
endpackage

// File: rtl/prom_addr_map.sv
// Maps a logical word/half-word address onto the memory pins.
module prom_addr_map #(
    parameter int AW = 27
) (
    input  logic [AW:0]   laddr,
    input  logic          x16,
    output logic [AW-1:0] pin_addr,
    output logic          pin_hsel
);
    always_comb begin
        if (x16) begin
            pin_addr = laddr[AW:1];
            pin_hsel = laddr[0];
        end else begin
            pin_addr = laddr[AW-1:0];
            pin_hsel = 1'b0;
        end
    end
endmodule

// File: rtl/prom_wait_timer.sv
// Down counter: load sets the count, done while it sits at zero.
module prom_wait_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/prom_lane_sel.sv
// Picks the valid data lanes for the current width.
module prom_lane_sel #(
    parameter int DW = 32
) (
    input  logic          x16,
    input  logic [DW-1:0] dq,
    output logic [DW-1:0] data
);
    localparam int HW = DW / 2;

    assign data = x16 ? {{(DW - HW){1'b0}}, dq[HW-1:0]} : dq;
endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader #(
    parameter int AW        = 27,
    parameter int DW        = 32,
    parameter int LW        = 8,
    parameter int PAGE_BITS = 3,
    parameter int RAND_CYC  = 13,
    parameter int PAGE_CYC  = 3,
    parameter int TURN_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_x16,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW:0]   req_addr,
    input  logic [LW-1:0] req_len,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_last,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_wide,
    output logic [AW-1:0] mem_addr,
    output logic          mem_hsel,
    output logic          mem_hsel_en,
    input  logic [DW-1:0] mem_dq
);
    import prom_rd_pkg::*;

    localparam int MAXC_A = (RAND_CYC > PAGE_CYC) ? RAND_CYC : PAGE_CYC;
    localparam int MAXC   = (MAXC_A > TURN_CYC) ? MAXC_A : TURN_CYC;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LD_RAND = CW'(RAND_CYC - 1);
    localparam logic [CW-1:0] LD_PAGE = CW'(PAGE_CYC - 1);
    localparam logic [CW-1:0] LD_TURN = CW'(TURN_CYC - 1);

    rd_state_t     state_q, state_d;
    logic [AW:0]   laddr_q;
    logic [LW-1:0] left_q;
    logic          x16_q;
    logic          wide_q;
    logic          ce_n_q;
    logic [AW-1:0] addr_q;
    logic          hsel_q;
    logic          hsel_en_q;
    logic          rsp_valid_q;
    logic [DW-1:0] rsp_data_q;
    logic          rsp_last_q;

    logic          fire, waiting, grab, is_last, page_hit, tmr_done, tmr_load;
    logic [CW-1:0] tmr_val;
    logic [AW:0]   map_in;
    logic          map_x16;
    logic [AW-1:0] map_addr;
    logic          map_hsel;
    logic [DW-1:0] lane_data;

    assign req_ready = (state_q == ST_IDLE);
    assign fire      = req_valid && req_ready;
    assign waiting   = (state_q == ST_RAND) || (state_q == ST_PAGE);
    assign grab      = waiting && tmr_done;
    assign is_last   = (left_q == '0);
    assign map_in    = req_ready ? req_addr : laddr_q + 1'b1;
    assign map_x16   = req_ready ? mode_x16 : x16_q;
    assign page_hit  = (map_addr[AW-1:PAGE_BITS] == addr_q[AW-1:PAGE_BITS]);

    prom_addr_map #(.AW(AW)) u_map (
        .laddr    (map_in),
        .x16      (map_x16),
        .pin_addr (map_addr),
        .pin_hsel (map_hsel)
    );

    prom_wait_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    prom_lane_sel #(.DW(DW)) u_lane (
        .x16  (x16_q),
        .dq   (mem_dq),
        .data (lane_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and wait selection
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = LD_RAND;
        unique case (state_q)
            ST_IDLE: begin
                if (fire) begin                          // ACCEPT
                    state_d  = ST_RAND;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RAND;
                end
            end
            ST_RAND, ST_PAGE: begin
                if (grab) begin
                    tmr_load = 1'b1;
                    if (is_last) begin                   // FINISH
                        state_d = ST_TURN;
                        tmr_val = LD_TURN;
                    end else if (page_hit) begin         // PAGE_HIT
                        state_d = ST_PAGE;
                        tmr_val = LD_PAGE;
                    end else begin                       // PAGE_MISS
                        state_d = ST_RAND;
                        tmr_val = LD_RAND;
                    end
                end
            end
            ST_TURN: begin
                if (tmr_done)                            // RELEASE
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered outputs and burst bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            laddr_q     <= '0;
            left_q      <= '0;
            x16_q       <= 1'b0;
            wide_q      <= 1'b1;
            ce_n_q      <= 1'b1;
            addr_q      <= '0;
            hsel_q      <= 1'b0;
            hsel_en_q   <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            rsp_last_q  <= 1'b0;
        end else begin
            rsp_valid_q <= grab;
            if (req_ready)
                wide_q <= ~mode_x16;
            if (fire) begin
                laddr_q   <= req_addr;
                left_q    <= req_len;
                x16_q     <= mode_x16;
                ce_n_q    <= 1'b0;
                addr_q    <= map_addr;
                hsel_q    <= map_hsel;
                hsel_en_q <= mode_x16;
            end
            if (grab) begin
                rsp_data_q <= lane_data;
                rsp_last_q <= is_last;
                if (is_last) begin
                    ce_n_q    <= 1'b1;
                    hsel_en_q <= 1'b0;
                end else begin
                    laddr_q <= laddr_q + 1'b1;
                    left_q  <= left_q - 1'b1;
                    addr_q  <= map_addr;
                    hsel_q  <= map_hsel;
                end
            end
        end
    end

    assign mem_ce_n    = ce_n_q;
    assign mem_oe_n    = ce_n_q;
    assign mem_wide    = wide_q;
    assign mem_addr    = addr_q;
    assign mem_hsel    = hsel_q;
    assign mem_hsel_en = hsel_en_q;
    assign rsp_valid   = rsp_valid_q;
    assign rsp_data    = rsp_data_q;
    assign rsp_last    = rsp_last_q;

    AST_IDLE_CHIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n)); // R2
    AST_HSEL_X16_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hsel_en |-> (!mem_wide && !mem_ce_n)); // R7
    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_wide)); // R10
    AST_RAND_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAND && $past(state_q == ST_RAND) && !$past(grab)) |-> $stable(mem_addr)); // R3
    AST_LAST_ENDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_last) |-> (mem_ce_n && !mem_hsel_en)); // R9
    AST_RSP_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R8
endmodule

// File: tb/prom_page_reader_tb_top.sv
module prom_page_reader_tb_top;
    localparam int AW = 27;
    localparam int DW = 32;
    localparam int LW = 8;
    localparam int RC = 13;
    localparam int PC = 3;
    localparam int TC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_x16 = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW:0]   req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          rsp_valid, rsp_last;
    logic [DW-1:0] rsp_data;
    logic          mem_ce_n, mem_oe_n, mem_wide, mem_hsel, mem_hsel_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq = '0;

    prom_page_reader #(.AW(AW), .DW(DW), .LW(LW), .PAGE_BITS(3),
                       .RAND_CYC(RC), .PAGE_CYC(PC), .TURN_CYC(TC)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_x16(mode_x16),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_hsel(mem_hsel), .mem_hsel_en(mem_hsel_en),
        .mem_dq(mem_dq)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int busy_lo = 1, ce_hi = 0, rdy_hi = 0;
    bit cur_x16 = 1'b0;
    int q_t[$];
    logic [31:0] q_d[$];
    bit q_l[$];
    int ce_age = 0, tag_age = 0, low_age = 0;
    logic [23:0] prev_tag = '0;
    logic [3:0]  prev_low = '0;

    function automatic logic [31:0] f32(input logic [26:0] a);
        return ({5'd0, a} * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction
    function automatic logic [15:0] f16(input logic [27:0] h);
        logic [31:0] p;
        p = {4'd0, h} * 32'h85EBCA6B;
        return p[23:8];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Per-clock reference comparison and memory model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit ce_lo, rdy;
            ce_lo = (busy_lo <= cyc) && (cyc < ce_hi);
            rdy   = !((busy_lo <= cyc) && (cyc < rdy_hi));
            check(req_ready == rdy, "R2/R9 ready", 32'(req_ready), 32'(rdy));
            check(mem_ce_n == !ce_lo, "R3/R5/R9 chip enable", 32'(mem_ce_n), 32'(!ce_lo));
            check(mem_oe_n == mem_ce_n, "R11 enables equal", 32'(mem_oe_n), 32'(mem_ce_n));
            check(mem_hsel_en == (ce_lo && cur_x16), "R7 half select drive",
                  32'(mem_hsel_en), 32'(ce_lo && cur_x16));
            if (q_t.size() > 0 && q_t[0] == cyc) begin
                check(rsp_valid == 1'b1, "R3/R4/R5 response timing", 32'(rsp_valid), 32'd1);
                check(rsp_data == q_d[0], "R6/R7 response data", rsp_data, q_d[0]);
                check(rsp_last == q_l[0], "R8 last flag", 32'(rsp_last), 32'(q_l[0]));
                void'(q_t.pop_front()); void'(q_d.pop_front()); void'(q_l.pop_front());
            end else begin
                check(rsp_valid == 1'b0, "R3/R8 no response", 32'(rsp_valid), 32'd0);
            end
        end
        // Memory model: data valid only after the proper stable windows
        if (mem_ce_n || mem_oe_n) begin
            ce_age = 0; tag_age = 0; low_age = 0;
        end else begin
            logic [3:0] low;
            ce_age++;
            low = {mem_addr[2:0], mem_hsel && mem_hsel_en};
            if (ce_age == 1 || mem_addr[26:3] != prev_tag) tag_age = 1; else tag_age++;
            if (ce_age == 1 || low != prev_low) low_age = 1; else low_age++;
            prev_tag = mem_addr[26:3];
            prev_low = low;
        end
        if (ce_age >= RC && tag_age >= RC && low_age >= PC) begin
            if (mem_wide) mem_dq = f32(mem_addr);
            else mem_dq = {16'hC3C3, f16({mem_addr, mem_hsel})};
        end else begin
            mem_dq = 32'hBAD0BAD0 ^ 32'(cyc);
        end
    end

    task automatic do_req(input logic [27:0] a, input int len);
        req_addr  = a;
        req_len   = LW'(len);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        begin
            int t;
            bit x;
            logic [27:0] la, pv;
            x = mode_x16;
            t = cyc + 1;
            busy_lo = cyc + 1;
            for (int i = 0; i <= len; i++) begin
                la = x ? a + 28'(i) : (a + 28'(i)) & 28'h7FFFFFF;
                if (i == 0) t += RC;
                else if (x ? (la[27:4] == pv[27:4]) : (la[26:3] == pv[26:3])) t += PC;
                else t += RC;
                q_t.push_back(t);
                q_d.push_back(x ? {16'h0, f16(la)} : f32(la[26:0]));
                q_l.push_back(i == len);
                pv = la;
            end
            ce_hi = t;
            rdy_hi = t + TC;
            cur_x16 = x;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (q_t.size() != 0 || cyc < rdy_hi) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_ce_n && mem_oe_n, "R1 enables high in reset", {mem_ce_n, mem_oe_n}, 32'd3);
        check(!rsp_valid, "R1 no response in reset", 32'(rsp_valid), 32'd0);
        check(!mem_hsel_en, "R1 half select off in reset", 32'(mem_hsel_en), 32'd0);
        check(req_ready, "R1 ready in reset", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3/R6 single word, upper request bit ignored in 32-bit mode
        do_req(28'h8000005, 0);
        wait_done();
        // R4/R5/R8 burst crossing a page edge
        do_req(28'h0000005, 5);
        wait_done();
        // R6 wrap at top of 32-bit space
        do_req(28'h7FFFFFE, 3);
        wait_done();
        // R7 16-bit mode, crossing half-word pages
        mode_x16 = 1'b1;
        repeat (2) @(negedge clk);
        check(mem_wide == 1'b0, "R10 strap follows mode when idle", 32'(mem_wide), 32'd0);
        do_req(28'h000000D, 19);
        wait_done();
        // R7 wrap at top of 16-bit space
        do_req(28'hFFFFFFE, 3);
        wait_done();
        // R10 mode change during burst is ignored until idle
        do_req(28'h0000100, 9);
        mode_x16 = 1'b0;
        repeat (4) @(negedge clk);
        check(mem_wide == 1'b0, "R10 strap held during burst", 32'(mem_wide), 32'd0);
        wait_done();
        check(mem_wide == 1'b1, "R10 strap updated after burst", 32'(mem_wide), 32'd1);
        // R2/R9 back-to-back requests with valid held
        do_req(28'h0000037, 2);
        do_req(28'h0000040, 8);
        do_req(28'h0000123, 0);
        wait_done();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule